// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is an up-counter built from chained four-bit digits. Each digit counts modulo 16 and can be cleared or preset on the rising clock edge. It has two count enables. The first is a broad enable shared by every digit. The second is a carry enable that passes from one digit to the next. Each digit also produces a terminal-count flag. That flag is gated only by the digit's own carry enable, so digits can be joined into wider counters without extra gates.

The top level joins a parameterized number of digits in lookahead form:

- The carry enable of each digit comes from the terminal-count flag of the digit below it.
- The broad enable of every digit above the lowest is the shared broad enable ANDed with the lowest digit's terminal-count flag.

The result behaves as one binary counter of four times the digit count in bits, with one terminal-count output for the whole counter.

The clear and preset inputs are active low and fully synchronous. No other reset is present: holding the clear input low for one edge puts the block in a known state. The counter has no streaming data path. Every pin is a plain level-sensitive control or status signal.

Top module: `cnt_chain`

## Requirements
- R1: The counter is binary and wraps modulo 2^(4·STAGES). With the default STAGES = 2, the value 0xFF advances to 0x00 on a counting edge.
- R2: While `clr_n` is low at a rising edge, `cnt` becomes all zeros after that edge, whatever the values of `ld_n`, `en_par`, `en_trk` and `ld_val`.
- R3: While `clr_n` is high and `ld_n` is low at a rising edge, `cnt` takes the value of `ld_val`, whatever the values of both enables.
- R4: While `clr_n` and `ld_n` are high and both `en_par` and `en_trk` are high at a rising edge, `cnt` increases by one.
- R5: While `clr_n` and `ld_n` are high and either enable is low at a rising edge, `cnt` keeps its value.
- R6: `tc_out` is high exactly when every bit of `cnt` is one and `en_trk` is high. It does not depend on `en_par` or `ld_n`, and it follows `en_trk` within the same cycle with no register in between.
- R7: A four-bit digit above the lowest one changes on a counting edge only when every lower digit holds 15. When that happens, it advances by one and the lower digits wrap to 0.
- R8: When modes compete, the order of precedence is clear, then preset, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous preset, active low |
| en_par | input | 1 | Broad count enable shared by all digits |
| en_trk | input | 1 | Carry enable of the lowest digit; also gates `tc_out` |
| ld_val | input | 4·STAGES | Preset value |
| cnt | output | 4·STAGES | Current count |
| tc_out | output | 1 | Terminal count of the whole counter |

## Verification
The bench sets up cycles where the preset and the terminal-count flag meet. It presets all ones while `en_trk` is high and checks that `tc_out` rises straight after that edge even though no count took place. It also checks that `en_par` held low at all ones leaves the flag high. Clear, preset and count are also requested together in single cycles. The outcome is compared against an independent priority model of the whole-width value. In each of these cycles, only the highest-ranked mode may show its effect on `cnt`.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int DIG_W = 4;

  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_COUNT = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic  clr_n,
  input  logic  ld_n,
  input  logic  en_par,
  input  logic  en_trk,
  output mode_e mode
);
  // Precedence: clear, then preset, then count, then hold (R8)
  always_comb begin
    if (!clr_n)                mode = M_CLEAR;
    else if (!ld_n)            mode = M_LOAD;
    else if (en_par && en_trk) mode = M_COUNT;
    else                       mode = M_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = DIG_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  mode_e mode;

  cnt_mode_sel u_sel (
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  always_ff @(posedge clk) begin
    unique case (mode)
      M_CLEAR: q <= '0;
      M_LOAD:  q <= d;
      M_COUNT: q <= q + 1'b1;
      default: q <= q;
    endcase
  end

  // Unregistered terminal count, gated by the carry enable only
  assign tc = (q == MAXV) && en_trk;

  // Checker state: armed once a clear edge has defined the register
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> (q == $past(d)));
  a_r4_count_step: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && en_par && en_trk) |=> (q == W'($past(q) + 1'b1)));
  a_r5_hold_still: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(en_par && en_trk)) |=> $stable(q));
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    clr_n,
  input  logic                    ld_n,
  input  logic                    en_par,
  input  logic                    en_trk,
  input  logic [STAGES*DIG_W-1:0] ld_val,
  output logic [STAGES*DIG_W-1:0] cnt,
  output logic                    tc_out
);
  localparam int W = STAGES * DIG_W;

  logic [STAGES-1:0] tc_v;
  logic [STAGES-1:0] par_v;
  logic [STAGES-1:0] trk_v;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_dig
      if (i == 0) begin : g_low
        assign par_v[i] = en_par;
        assign trk_v[i] = en_trk;
      end else begin : g_up
        // Lookahead: broad enable qualified by the lowest digit's flag
        assign par_v[i] = en_par & tc_v[0];
        assign trk_v[i] = tc_v[i-1];
      end

      cnt_stage #(.W(DIG_W)) u_dig (
        .clk    (clk),
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .en_par (par_v[i]),
        .en_trk (trk_v[i]),
        .d      (ld_val[i*DIG_W +: DIG_W]),
        .q      (cnt[i*DIG_W +: DIG_W]),
        .tc     (tc_v[i])
      );
    end
  endgenerate

  assign tc_out = tc_v[STAGES-1];

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  a_r6_tc_full: assert property (@(posedge clk) disable iff (!armed)
    tc_out |-> ((cnt == {W{1'b1}}) && en_trk));

  generate
    if (STAGES > 1) begin : g_chk_up
      a_r7_upper_waits: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && ld_n && (cnt[DIG_W-1:0] != {DIG_W{1'b1}}))
        |=> (cnt[W-1:DIG_W] == $past(cnt[W-1:DIG_W])));
    end
  endgenerate
endmodule

// File: tb/cnt_chain_bench.sv
module cnt_chain_bench;
  localparam int STAGES = 2;
  localparam int W = STAGES * 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic clr_n = 1'b1, ld_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] cnt;
  logic tc_out;

  logic [W-1:0] exp_cnt = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cnt_chain #(.STAGES(STAGES)) u_cnt_chain (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(en_par),
    .en_trk(en_trk), .ld_val(ld_val), .cnt(cnt), .tc_out(tc_out)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Drive one cycle's inputs, update the reference model, edge, then check
  task automatic step(string tag, logic c, logic l, logic p, logic t,
                      logic [W-1:0] v);
    clr_n = c; ld_n = l; en_par = p; en_trk = t; ld_val = v;
    if (!c)          exp_cnt = '0;
    else if (!l)     exp_cnt = v;
    else if (p && t) exp_cnt = exp_cnt + 1'b1;
    @(posedge clk); #5;
    chk({tag, " cnt"}, cnt, exp_cnt);
    chk({tag, " tc_out"}, W'(tc_out), W'((exp_cnt == ONES) && t));
  endtask

  task automatic t_reset();
    step("R2 clear", 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5);
  endtask

  task automatic t_count();
    for (int k = 0; k < 20; k++) step("R4 count", 1'b1, 1'b1, 1'b1, 1'b1, '0);
  endtask

  task automatic t_wrap();
    step("R3 load FE", 1'b1, 1'b0, 1'b0, 1'b0, 8'hFE);
    step("R1 to FF", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    step("R1 wrap 00", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R1 wrap value", cnt, 8'h00);
  endtask

  task automatic t_hold();
    step("R3 load 3C", 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C);
    for (int k = 0; k < 3; k++) step("R5 par low", 1'b1, 1'b1, 1'b0, 1'b1, '0);
    for (int k = 0; k < 3; k++) step("R5 trk low", 1'b1, 1'b1, 1'b1, 1'b0, '0);
    chk("R5 held value", cnt, 8'h3C);
  endtask

  task automatic t_tc();
    // R6: preset all ones with en_trk high; flag rises right after the edge
    step("R6 load FF trk", 1'b1, 1'b0, 1'b0, 1'b1, ONES);
    step("R6 par low at FF", 1'b1, 1'b1, 1'b0, 1'b1, '0);
    en_trk = 1'b0; #1;
    chk("R6 trk drop same cycle", W'(tc_out), W'(0));
    en_trk = 1'b1; #1;
    chk("R6 trk rise same cycle", W'(tc_out), W'(1));
    ld_n = 1'b0; #1;
    chk("R6 ld_n no effect", W'(tc_out), W'(1));
    ld_n = 1'b1;
  endtask

  task automatic t_prio();
    step("R8 clear beats load", 1'b0, 1'b0, 1'b1, 1'b1, 8'h77);
    chk("R8 clear value", cnt, 8'h00);
    step("R8 load beats count", 1'b1, 1'b0, 1'b1, 1'b1, 8'h42);
    chk("R8 load value", cnt, 8'h42);
    step("R2 clear ignores enables", 1'b0, 1'b1, 1'b1, 1'b1, '0);
    step("R3 load no enables", 1'b1, 1'b0, 1'b0, 1'b0, 8'h9B);
  endtask

  task automatic t_carry();
    step("R7 load 0F", 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
    step("R7 carry", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R7 carry value", cnt, 8'h10);
    step("R7 load 1E", 1'b1, 1'b0, 1'b0, 1'b0, 8'h1E);
    step("R7 no carry", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R7 upper still", cnt, 8'h1F);
    step("R7 carry trk low", 1'b1, 1'b1, 1'b1, 1'b0, '0);
    step("R7 carry par low", 1'b1, 1'b1, 1'b0, 1'b1, '0);
    step("R7 carry 20", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R7 second carry", cnt, 8'h20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    @(posedge clk); #5;
    t_reset();
    t_count();
    t_wrap();
    t_hold();
    t_tc();
    t_prio();
    t_carry();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule